// File: doc/BRIEF.md
# Conflict-Checked Command Set Claimer

This block hands out command sets to new active requests. A command set is a group of command slots; each slot holds a target address and a command-enable bit, and both are supplied to the block as flat input vectors. The block keeps its own in-use bitmap, one bit per set. A request carries up to `REQ_MAX` target addresses and a count saying how many of them are valid. The block walks every slot of every set in the selected group, one slot per clock, and compares that slot's address against all valid request addresses in parallel.

If an enabled slot of an in-use set holds an address the request also names, the request is refused with busy. This happens even when free sets remain in the group. Otherwise the block grants the lowest-numbered free set in the group and marks it in use. A completion release clears a set's in-use bit. The group is normally the active range (base plus count). When the active count is zero, the wake range is used instead.

The controller has three states. `ST_IDLE` accepts a request. It moves to `ST_SCAN` when the group count is non-zero, and straight to `ST_DECIDE` when it is zero. `ST_SCAN` advances slot by slot through the group and moves to `ST_DECIDE` after the last slot of the last set. `ST_DECIDE` posts the result and always returns to `ST_IDLE`.

Top module: `cmdset_claimer`

## Requirements
- R1: After reset the in-use bitmap is all zero, `ready_o` is 1 and `done_o`, `busy_o`, `grant_o` are 0.
- R2: The group is sets `act_base_i` to `act_base_i+act_cnt_i-1`. When `act_cnt_i` is 0, the group is sets `wake_base_i` to `wake_base_i+wake_cnt_i-1`. Sets outside the group are never granted and never cause a conflict.
- R3: A request is answered busy when one of its first `req_cnt_i` addresses equals the address of a slot that meets all of the following: the slot's enable bit is 1, its set is in use, and its set lies in the group. This holds even if free sets exist. Address k of the request is `req_addr_i[16k+15:16k]`. Slot j of set s is enable bit `s*SLOTS+j` and address field `s*SLOTS+j`.
- R4: With no conflict, the grant is the lowest-numbered set in the group whose in-use bit is 0. If there is none, the answer is busy.
- R5: A grant sets that set's in-use bit. A release (`rel_valid_i` with `rel_id_i`) clears the bit on the next clock edge.
- R6: A release that falls in the `ST_DECIDE` cycle takes effect before the free-set search. The released set can therefore be granted in that same decision.
- R7: `done_o` pulses for exactly one cycle, `group_count*SLOTS+1` cycles after the accepting edge. With `done_o`, exactly one of `busy_o` and `grant_o` is 1, and both are 0 outside `done_o`. `ready_o` is 0 while a request is in progress.
- R8: A request to an empty group (both counts 0) is answered busy one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_base_i | input | SET_W | First set of the active group |
| act_cnt_i | input | CNT_W | Number of sets in the active group |
| wake_base_i | input | SET_W | First set of the fallback group |
| wake_cnt_i | input | CNT_W | Number of sets in the fallback group |
| slot_en_i | input | NUM_SETS*SLOTS | Command-enable bit per slot |
| slot_addr_i | input | NUM_SETS*SLOTS*ADDR_W | Stored target address per slot |
| req_valid_i | input | 1 | New request, taken while `ready_o` is 1 |
| req_cnt_i | input | RCNT_W | Number of valid request addresses |
| req_addr_i | input | REQ_MAX*ADDR_W | Request addresses |
| rel_valid_i | input | 1 | Release of a completed set |
| rel_id_i | input | SET_W | Set being released |
| ready_o | output | 1 | Controller is in `ST_IDLE` |
| done_o | output | 1 | Result pulse |
| busy_o | output | 1 | Request refused |
| grant_o | output | 1 | Request granted |
| grant_id_o | output | SET_W | Granted set |
| in_use_o | output | NUM_SETS | In-use bitmap |

## Verification
A completion release and a claim decision can fall in the same cycle. The bench times a release of the last busy set in a full group so that it lands exactly in the `ST_DECIDE` cycle. It does this by counting the scan length, which is the group size times the slots per set.

The outcome is judged at the ports. The result must be a grant of the released set, with the in-use bitmap unchanged. The result must also arrive at the expected latency. An earlier table entry posts the same request against the same full group without a release, and that entry must be busy.

// File: rtl/cmdset_claimer_pkg.sv
package cmdset_claimer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_DECIDE = 2'd2
    } claim_state_e;
endpackage

// File: rtl/cmdset_group_pick.sv
// Chooses the scanned group: active range, or the wake range if active is empty (R2).
module cmdset_group_pick #(
    parameter int SET_W = 3,
    parameter int CNT_W = 4
) (
    input  logic [SET_W-1:0] act_base,
    input  logic [CNT_W-1:0] act_cnt,
    input  logic [SET_W-1:0] wake_base,
    input  logic [CNT_W-1:0] wake_cnt,
    output logic [SET_W-1:0] grp_base,
    output logic [CNT_W-1:0] grp_cnt
);
    always_comb begin
        if (act_cnt == '0) begin
            grp_base = wake_base;
            grp_cnt  = wake_cnt;
        end else begin
            grp_base = act_base;
            grp_cnt  = act_cnt;
        end
    end
endmodule

// File: rtl/cmdset_addr_cmp.sv
// One stored slot address against every valid request address in parallel (R3).
module cmdset_addr_cmp #(
    parameter int ADDR_W  = 16,
    parameter int REQ_MAX = 16,
    parameter int RCNT_W  = 5
) (
    input  logic [ADDR_W-1:0]         slot_addr,
    input  logic [REQ_MAX*ADDR_W-1:0] req_addr,
    input  logic [RCNT_W-1:0]         req_cnt,
    output logic                      hit
);
    logic [REQ_MAX-1:0] lane_hit;

    for (genvar k = 0; k < REQ_MAX; k++) begin : g_lane
        assign lane_hit[k] = (RCNT_W'(k) < req_cnt) &&
                             (req_addr[k*ADDR_W +: ADDR_W] == slot_addr);
    end

    assign hit = |lane_hit;
endmodule

// File: rtl/cmdset_free_pick.sv
// Lowest-numbered clear bit inside [base, base+cnt) (R4).
module cmdset_free_pick #(
    parameter int NUM_SETS = 8,
    parameter int SET_W    = 3,
    parameter int CNT_W    = 4
) (
    input  logic [NUM_SETS-1:0] busy_map,
    input  logic [SET_W-1:0]    base,
    input  logic [CNT_W-1:0]    cnt,
    output logic                found,
    output logic [SET_W-1:0]    id
);
    always_comb begin
        found = 1'b0;
        id    = '0;
        for (int i = NUM_SETS - 1; i >= 0; i--) begin
            if ((i >= int'(base)) && (i < int'(base) + int'(cnt)) && !busy_map[i]) begin
                found = 1'b1;
                id    = SET_W'(i);
            end
        end
    end
endmodule

// File: rtl/cmdset_claimer.sv
module cmdset_claimer
    import cmdset_claimer_pkg::*;
#(
    parameter  int NUM_SETS = 8,
    parameter  int SLOTS    = 4,
    parameter  int ADDR_W   = 16,
    parameter  int REQ_MAX  = 16,
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int CNT_W    = $clog2(NUM_SETS + 1),
    localparam int RCNT_W   = $clog2(REQ_MAX + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SET_W-1:0]                 act_base_i,
    input  logic [CNT_W-1:0]                 act_cnt_i,
    input  logic [SET_W-1:0]                 wake_base_i,
    input  logic [CNT_W-1:0]                 wake_cnt_i,
    input  logic [NUM_SETS*SLOTS-1:0]        slot_en_i,
    input  logic [NUM_SETS*SLOTS*ADDR_W-1:0] slot_addr_i,
    input  logic                             req_valid_i,
    input  logic [RCNT_W-1:0]                req_cnt_i,
    input  logic [REQ_MAX*ADDR_W-1:0]        req_addr_i,
    input  logic                             rel_valid_i,
    input  logic [SET_W-1:0]                 rel_id_i,
    output logic                             ready_o,
    output logic                             done_o,
    output logic                             busy_o,
    output logic                             grant_o,
    output logic [SET_W-1:0]                 grant_id_o,
    output logic [NUM_SETS-1:0]              in_use_o
);
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int IDX_W  = SET_W + 2;
    localparam int FLAT_W = IDX_W + SLOT_W;

    claim_state_e state_q, state_d;

    logic [SET_W-1:0]          grp_base, base_q;
    logic [CNT_W-1:0]          grp_cnt, cnt_q;
    logic [REQ_MAX*ADDR_W-1:0] req_q;
    logic [RCNT_W-1:0]         rcnt_q;
    logic [IDX_W-1:0]          scan_set_q;
    logic [SLOT_W-1:0]         scan_slot_q;
    logic                      hit_q;
    logic [NUM_SETS-1:0]       in_use_q, in_use_d;
    logic [NUM_SETS-1:0]       rel_mask, grant_mask;

    logic [FLAT_W-1:0]         flat_idx;
    logic                      set_valid;
    logic [ADDR_W-1:0]         cur_addr;
    logic                      cur_en, cur_busy, cmp_hit;
    logic                      last_slot, last_set;
    logic                      free_found, take;
    logic [SET_W-1:0]          free_id;

    cmdset_group_pick #(.SET_W(SET_W), .CNT_W(CNT_W)) u_group (
        .act_base (act_base_i),
        .act_cnt  (act_cnt_i),
        .wake_base(wake_base_i),
        .wake_cnt (wake_cnt_i),
        .grp_base (grp_base),
        .grp_cnt  (grp_cnt)
    );

    // Slot currently under inspection
    assign flat_idx  = FLAT_W'(scan_set_q) * FLAT_W'(SLOTS) + FLAT_W'(scan_slot_q);
    assign set_valid = (scan_set_q < IDX_W'(NUM_SETS));

    always_comb begin
        cur_addr = '0;
        cur_en   = 1'b0;
        cur_busy = 1'b0;
        if (set_valid) begin
            cur_addr = slot_addr_i[flat_idx*ADDR_W +: ADDR_W];
            cur_en   = slot_en_i[flat_idx];
            cur_busy = in_use_q[scan_set_q[SET_W-1:0]];
        end
    end

    cmdset_addr_cmp #(.ADDR_W(ADDR_W), .REQ_MAX(REQ_MAX), .RCNT_W(RCNT_W)) u_cmp (
        .slot_addr(cur_addr),
        .req_addr (req_q),
        .req_cnt  (rcnt_q),
        .hit      (cmp_hit)
    );

    assign last_slot = (scan_slot_q == SLOT_W'(SLOTS - 1));
    assign last_set  = (scan_set_q == IDX_W'(base_q) + IDX_W'(cnt_q) - IDX_W'(1));

    // Release is applied ahead of the free search (R6)
    assign rel_mask = rel_valid_i ? (NUM_SETS'(1) << rel_id_i) : '0;

    cmdset_free_pick #(.NUM_SETS(NUM_SETS), .SET_W(SET_W), .CNT_W(CNT_W)) u_free (
        .busy_map(in_use_q & ~rel_mask),
        .base    (base_q),
        .cnt     (cnt_q),
        .found   (free_found),
        .id      (free_id)
    );

    assign take       = (state_q == ST_DECIDE) && !hit_q && free_found;
    assign grant_mask = take ? (NUM_SETS'(1) << free_id) : '0;
    assign in_use_d   = (in_use_q & ~rel_mask) | grant_mask;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) state_d = (grp_cnt == '0) ? ST_DECIDE : ST_SCAN;
            end
            ST_SCAN: begin
                if (last_slot && last_set) state_d = ST_DECIDE;
            end
            ST_DECIDE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            cnt_q       <= '0;
            req_q       <= '0;
            rcnt_q      <= '0;
            scan_set_q  <= '0;
            scan_slot_q <= '0;
            hit_q       <= 1'b0;
            in_use_q    <= '0;
            done_o      <= 1'b0;
            busy_o      <= 1'b0;
            grant_o     <= 1'b0;
            grant_id_o  <= '0;
        end else begin
            done_o   <= 1'b0;
            busy_o   <= 1'b0;
            grant_o  <= 1'b0;
            in_use_q <= in_use_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        base_q      <= grp_base;
                        cnt_q       <= grp_cnt;
                        req_q       <= req_addr_i;
                        rcnt_q      <= req_cnt_i;
                        scan_set_q  <= IDX_W'(grp_base);
                        scan_slot_q <= '0;
                        hit_q       <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (cur_en && cur_busy && cmp_hit) hit_q <= 1'b1;
                    if (last_slot) begin
                        scan_slot_q <= '0;
                        scan_set_q  <= scan_set_q + IDX_W'(1);
                    end else begin
                        scan_slot_q <= scan_slot_q + SLOT_W'(1);
                    end
                end
                ST_DECIDE: begin
                    done_o     <= 1'b1;
                    busy_o     <= !take;
                    grant_o    <= take;
                    grant_id_o <= take ? free_id : '0;
                end
                default: ;
            endcase
        end
    end

    assign ready_o  = (state_q == ST_IDLE);
    assign in_use_o = in_use_q;
endmodule

// File: rtl/cmdset_claimer_chk.sv
module cmdset_claimer_chk #(
    parameter int NUM_SETS = 8,
    parameter int SET_W    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ready_o,
    input logic                done_o,
    input logic                busy_o,
    input logic                grant_o,
    input logic [SET_W-1:0]    grant_id_o,
    input logic [NUM_SETS-1:0] in_use_o,
    input logic                rel_valid_i,
    input logic [SET_W-1:0]    rel_id_i
);
    logic [NUM_SETS-1:0] prev_use_q;
    logic                prev_rel_v_q;
    logic [SET_W-1:0]    prev_rel_id_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_use_q    <= '0;
            prev_rel_v_q  <= 1'b0;
            prev_rel_id_q <= '0;
        end else begin
            prev_use_q    <= in_use_o;
            prev_rel_v_q  <= rel_valid_i;
            prev_rel_id_q <= rel_id_i;
        end
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o ^ grant_o)) else $error("result not exclusive"); // R7
    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!busy_o && !grant_o)) else $error("result without done"); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R7
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ready_o) else $error("not idle at done"); // R7
    AST_GRANT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> in_use_o[grant_id_o]) else $error("granted set not marked"); // R5
    AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (!prev_use_q[grant_id_o] ||
                     (prev_rel_v_q && prev_rel_id_q == grant_id_o)))
        else $error("granted a busy set"); // R6
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        prev_rel_v_q |-> (!in_use_o[prev_rel_id_q] ||
                          (grant_o && grant_id_o == prev_rel_id_q)))
        else $error("release did not clear"); // R5
endmodule

bind cmdset_claimer cmdset_claimer_chk #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_o    (ready_o),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .grant_o    (grant_o),
    .grant_id_o (grant_id_o),
    .in_use_o   (in_use_o),
    .rel_valid_i(rel_valid_i),
    .rel_id_i   (rel_id_i)
);

// File: tb/test_cmdset_claimer.sv
`timescale 1ns/1ps
module test_cmdset_claimer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   act_base = 3'd0, wake_base = 3'd4;
    logic [3:0]   act_cnt = 4'd4, wake_cnt = 4'd4;
    logic [31:0]  slot_en;
    logic [511:0] slot_addr;
    logic         req_valid = 1'b0;
    logic [4:0]   req_cnt = '0;
    logic [255:0] req_addr = '0;
    logic         rel_valid = 1'b0;
    logic [2:0]   rel_id = '0;
    logic         ready, done, busy, grant;
    logic [2:0]   grant_id;
    logic [7:0]   in_use;

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cmdset_claimer i_cmdset_claimer (
        .clk(clk), .rst_n(rst_n),
        .act_base_i(act_base), .act_cnt_i(act_cnt),
        .wake_base_i(wake_base), .wake_cnt_i(wake_cnt),
        .slot_en_i(slot_en), .slot_addr_i(slot_addr),
        .req_valid_i(req_valid), .req_cnt_i(req_cnt), .req_addr_i(req_addr),
        .rel_valid_i(rel_valid), .rel_id_i(rel_id),
        .ready_o(ready), .done_o(done), .busy_o(busy), .grant_o(grant),
        .grant_id_o(grant_id), .in_use_o(in_use)
    );

    // {count, addr0, addr1, exp_busy, exp_id, exp_in_use}; group = sets 0..3
    localparam logic [48:0] VEC [0:6] = '{
        {5'd1, 16'h2000, 16'h0000, 1'b0, 3'd0, 8'h01},
        {5'd1, 16'h1001, 16'h0000, 1'b1, 3'd0, 8'h01},
        {5'd1, 16'h1011, 16'h0000, 1'b0, 3'd1, 8'h03},
        {5'd1, 16'h1012, 16'h0000, 1'b0, 3'd2, 8'h07},
        {5'd2, 16'h3000, 16'h1023, 1'b1, 3'd0, 8'h07},
        {5'd1, 16'h3000, 16'h1023, 1'b0, 3'd3, 8'h0F},
        {5'd1, 16'h3000, 16'h0000, 1'b1, 3'd0, 8'h0F}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic claim(input logic [4:0] cnt, input logic [15:0] a0, input logic [15:0] a1,
                         input bit rel_en, input logic [2:0] rid, input int rel_cycle,
                         output bit b, output logic [2:0] gid, output int lat, output bit rdy0);
        lat = -1; b = 1'b0; gid = '0; rdy0 = 1'b1;
        @(negedge clk);
        req_cnt  = cnt;
        req_addr = {16{16'hEEEE}};
        req_addr[15:0]  = a0;
        req_addr[31:16] = a1;
        req_valid = 1'b1;
        @(posedge clk);
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (n == 0) begin
                req_valid = 1'b0;
                rdy0 = ready;
            end
            rel_valid = rel_en && (n == rel_cycle);
            rel_id    = rid;
            if (done) begin
                lat = n;
                b   = busy;
                gid = grant_id;
                break;
            end
        end
        rel_valid = 1'b0;
    endtask

    task automatic release_set(input logic [2:0] id);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_id    = id;
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit b, rdy0;
        logic [2:0] gid;
        int lat;

        for (int s = 0; s < 8; s++)
            for (int j = 0; j < 4; j++)
                slot_addr[(s*4+j)*16 +: 16] = 16'h1000 + 16'(s*16 + j);
        slot_en = 32'hFFFF_FFBF;   // set 1 slot 2 disabled

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_use == 8'h00, "R1 in_use", in_use, 0);
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk({done, busy, grant} == 3'b000, "R1 result", {done, busy, grant}, 0);

        // Table walk: conflict and allocation in the active group
        for (int v = 0; v < 7; v++) begin
            claim(VEC[v][48:44], VEC[v][43:28], VEC[v][27:12], 1'b0, 3'd0, 0, b, gid, lat, rdy0);
            chk(b == VEC[v][11], $sformatf("R3 R4 vec%0d busy", v), b, VEC[v][11]);
            if (!VEC[v][11])
                chk(gid == VEC[v][10:8], $sformatf("R4 vec%0d id", v), gid, VEC[v][10:8]);
            chk(in_use == VEC[v][7:0], $sformatf("R5 vec%0d in_use", v), in_use, VEC[v][7:0]);
            chk(lat == 17, $sformatf("R7 vec%0d latency", v), lat, 17);
            if (v == 0) chk(rdy0 == 1'b0, "R7 ready low while scanning", rdy0, 0);
        end

        // Releases, then lowest-free selection
        release_set(3'd2);
        chk(in_use == 8'h0B, "R5 release set2", in_use, 8'h0B);
        release_set(3'd1);
        chk(in_use == 8'h09, "R5 release set1", in_use, 8'h09);
        claim(5'd1, 16'h4000, 16'h0, 1'b0, 3'd0, 0, b, gid, lat, rdy0);
        chk(!b && gid == 3'd1, "R4 lowest free", gid, 1);
        claim(5'd1, 16'h4001, 16'h0, 1'b0, 3'd0, 0, b, gid, lat, rdy0);
        chk(!b && gid == 3'd2, "R4 next free", gid, 2);
        chk(in_use == 8'h0F, "R5 group full", in_use, 8'h0F);

        // Release landing in the decision cycle of a full group
        claim(5'd1, 16'h4002, 16'h0, 1'b1, 3'd3, 16, b, gid, lat, rdy0);
        chk(!b, "R6 release wins busy", b, 0);
        chk(gid == 3'd3, "R6 released set granted", gid, 3);
        chk(in_use == 8'h0F, "R6 in_use", in_use, 8'h0F);
        chk(lat == 17, "R7 latency with release", lat, 17);

        // Fallback group: sets 4..5
        act_cnt = 4'd0; wake_base = 3'd4; wake_cnt = 4'd2;
        claim(5'd1, 16'h5000, 16'h0, 1'b0, 3'd0, 0, b, gid, lat, rdy0);
        chk(!b && gid == 3'd4, "R2 fallback grant", gid, 4);
        chk(lat == 9, "R7 fallback latency", lat, 9);
        claim(5'd1, 16'h1040, 16'h0, 1'b0, 3'd0, 0, b, gid, lat, rdy0);
        chk(b, "R3 conflict in fallback", b, 1);
        claim(5'd1, 16'h1000, 16'h0, 1'b0, 3'd0, 0, b, gid, lat, rdy0);
        chk(!b && gid == 3'd5, "R2 out-of-group set ignored", gid, 5);
        chk(in_use == 8'h3F, "R5 in_use fallback", in_use, 8'h3F);
        claim(5'd1, 16'h5001, 16'h0, 1'b0, 3'd0, 0, b, gid, lat, rdy0);
        chk(b, "R4 fallback full", b, 1);

        // Empty group
        wake_cnt = 4'd0;
        claim(5'd1, 16'h6000, 16'h0, 1'b0, 3'd0, 0, b, gid, lat, rdy0);
        chk(b, "R8 empty group busy", b, 1);
        chk(lat == 1, "R8 empty group latency", lat, 1);
        chk(in_use == 8'h3F, "R8 in_use unchanged", in_use, 8'h3F);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule